// File: doc/BRIEF.md
# DSSS Packet Modulation Sequencer

This block steps one transmit packet through three phases: a synchronisation preamble, a header and a payload. For each phase it chooses the modulation scheme the downstream modulators must apply. It also sets the symbol pace by asking for the next symbol's worth of bits at a fixed interval. The preamble always uses DBPSK. The header uses DBPSK or DQPSK, as configured. The payload uses DBPSK, DQPSK or CCK, according to a two-bit rate code. The sequencer makes the preamble bit values itself: a run of sync ones, then a start-of-frame word. Header and payload bits come from outside the block, one group per request.

A start pulse in the idle phase captures the header mode, the rate code and the payload length in bits. From the next cycle on, the block issues one symbol request every `SYM_CYC` cycles. Each request carries the modulation code and the number of bits the symbol consumes. After the last payload request, a one-cycle done pulse marks the return to idle. The scrambler, the spreader and the modulators sit outside this block.

Top module: `dsss_pkt_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, the phase reads idle (0), no symbol request is raised and done is low.
- R2: A start sampled in idle makes the first symbol request appear in the very next cycle, with phase code 1 (preamble). Phases then follow the order idle(0) → preamble(1) → header(2) → payload(3) → idle, and the payload is skipped only as R7 states.
- R3: The preamble has 144 symbols of 1 bit each, all with modulation code 0 (DBPSK). The generated bit is 1 for the first 128 symbols. The last 16 symbols carry `SFD_WORD`, most significant bit first. The generated bit is 0 outside the preamble.
- R4: The header carries 48 bits. With header mode 0 this is 48 DBPSK symbols of 1 bit (code 0). With header mode 1 it is 24 DQPSK symbols of 2 bits (code 1).
- R5: The payload rate code selects the symbol type: 0 gives DBPSK (code 0) at 1 bit per symbol, 1 gives DQPSK (code 1) at 2 bits, 2 gives CCK (code 2) at 4 bits and 3 gives CCK (code 2) at 8 bits.
- R6: When the payload length is not a multiple of the bits per symbol, the final payload symbol reports only the bits that remain.
- R7: A payload length of zero skips the payload phase, so the packet ends after the header.
- R8: Symbol requests arrive exactly `SYM_CYC` cycles apart through the whole packet, across phase boundaries.
- R9: Done is high for exactly one cycle, the cycle after the last symbol request. In that cycle the phase reads idle.
- R10: A start during a packet is ignored. Changes to the header mode, rate code or length inputs during a packet have no effect on that packet.
- R11: The modulation code changes only when the phase changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a packet (taken only in idle) |
| hdr_dqpsk_i | input | 1 | Header modulation: 0 DBPSK, 1 DQPSK |
| rate_i | input | 2 | Payload rate code (see R5) |
| len_i | input | LEN_W | Payload length in bits |
| phase_o | output | 2 | Current phase: 0 idle, 1 preamble, 2 header, 3 payload |
| mod_o | output | 2 | Modulation: 0 DBPSK, 1 DQPSK, 2 CCK |
| bit_req_o | output | 1 | Request for the next symbol's bits |
| sym_bits_o | output | 4 | Bits consumed by the requested symbol (0 when no request) |
| pre_bit_o | output | 1 | Generated preamble bit for the requested symbol |
| done_o | output | 1 | One-cycle end-of-packet pulse |

## Verification
The assertions check on every cycle that the phase order is legal and that the modulation never changes inside a phase. They also check that the preamble only uses 1-bit DBPSK symbols, that the header never selects CCK, and that done is a single-cycle pulse raised in idle with no request. Only the bench scenarios can show the symbol counts per phase, the start-of-frame bit pattern, the short final payload symbol, the exact request spacing and the done timing. The same holds for the zero-length packet and for start or configuration changes ignored in the middle of a packet.

// File: rtl/dsss_seq_pkg.sv
package dsss_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_HDR  = 2'd2,
    PH_PAY  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    MOD_DBPSK = 2'd0,
    MOD_DQPSK = 2'd1,
    MOD_CCK   = 2'd2
  } mod_e;

  localparam int PRE_BITS  = 144;
  localparam int SYNC_BITS = 128;
  localparam int SFD_BITS  = PRE_BITS - SYNC_BITS;
  localparam int HDR_BITS  = 48;

  function automatic logic [3:0] rate_bits(input logic [1:0] rc);
    case (rc)
      2'd0:    rate_bits = 4'd1;
      2'd1:    rate_bits = 4'd2;
      2'd2:    rate_bits = 4'd4;
      default: rate_bits = 4'd8;
    endcase
  endfunction

  function automatic mod_e rate_mod(input logic [1:0] rc);
    case (rc)
      2'd0:    rate_mod = MOD_DBPSK;
      2'd1:    rate_mod = MOD_DQPSK;
      default: rate_mod = MOD_CCK;
    endcase
  endfunction

endpackage

// File: rtl/dsss_rst_sync.sv
module dsss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dsss_sym_pace.sv
module dsss_sym_pace #(
  parameter int SYM_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic strobe_o
);
  localparam int PW = (SYM_CYC > 1) ? $clog2(SYM_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(SYM_CYC - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/dsss_bit_ctr.sv
module dsss_bit_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic [3:0]       bps_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             last_o,
  output logic [3:0]       take_o
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  assign last_o = (rem_q <= CNT_W'(bps_i));
  assign take_o = last_o ? rem_q[3:0] : bps_i;

  always_comb begin
    rem_en = load_i | dec_i;
    if (load_i) rem_d = load_val_i;
    else        rem_d = rem_q - CNT_W'(take_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign rem_o = rem_q;
endmodule

// File: rtl/dsss_pre_gen.sv
module dsss_pre_gen #(
  parameter int          CNT_W    = 12,
  parameter logic [15:0] SFD_WORD = 16'hF3A0
) (
  input  logic [CNT_W-1:0] rem_i,
  output logic             bit_o
);
  import dsss_seq_pkg::*;

  logic [3:0] sel;

  always_comb begin
    sel   = rem_i[3:0] - 4'd1;
    bit_o = (rem_i > CNT_W'(SFD_BITS)) ? 1'b1 : SFD_WORD[sel];
  end
endmodule

// File: rtl/dsss_pkt_seq.sv
module dsss_pkt_seq #(
  parameter int          LEN_W    = 12,
  parameter int          SYM_CYC  = 2,
  parameter logic [15:0] SFD_WORD = 16'hF3A0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hdr_dqpsk_i,
  input  logic [1:0]       rate_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [1:0]       phase_o,
  output logic [1:0]       mod_o,
  output logic             bit_req_o,
  output logic [3:0]       sym_bits_o,
  output logic             pre_bit_o,
  output logic             done_o
);
  import dsss_seq_pkg::*;

  localparam int CNT_W = (LEN_W > 8) ? LEN_W : 8;

  logic             rst_int_n;
  phase_e           phase_q, phase_d;
  logic             hdrq_q;
  logic [1:0]       rate_q;
  logic [LEN_W-1:0] len_q;
  logic             cfg_en;
  logic             done_q, done_d;
  logic             strobe, run;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] rem;
  logic             last;
  logic [3:0]       take;
  logic [3:0]       bps;
  mod_e             mod_c;
  logic             adv;
  logic             pre_bit_raw;

  dsss_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign run = (phase_q != PH_IDLE);

  dsss_sym_pace #(.SYM_CYC(SYM_CYC)) u_pace (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_i    (run),
    .strobe_o (strobe)
  );

  dsss_bit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (ld),
    .load_val_i (ld_val),
    .dec_i      (strobe),
    .bps_i      (bps),
    .rem_o      (rem),
    .last_o     (last),
    .take_o     (take)
  );

  dsss_pre_gen #(.CNT_W(CNT_W), .SFD_WORD(SFD_WORD)) u_pre (
    .rem_i (rem),
    .bit_o (pre_bit_raw)
  );

  // modulation and symbol width per phase
  always_comb begin
    case (phase_q)
      PH_PRE: begin
        bps   = 4'd1;
        mod_c = MOD_DBPSK;
      end
      PH_HDR: begin
        bps   = hdrq_q ? 4'd2 : 4'd1;
        mod_c = hdrq_q ? MOD_DQPSK : MOD_DBPSK;
      end
      PH_PAY: begin
        bps   = rate_bits(rate_q);
        mod_c = rate_mod(rate_q);
      end
      default: begin
        bps   = 4'd0;
        mod_c = MOD_DBPSK;
      end
    endcase
  end

  assign adv = strobe && last;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    done_d  = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    cfg_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_PRE;
          ld      = 1'b1;
          ld_val  = CNT_W'(PRE_BITS);
          cfg_en  = 1'b1;
        end
      end
      PH_PRE: begin
        if (adv) begin
          phase_d = PH_HDR;
          ld      = 1'b1;
          ld_val  = CNT_W'(HDR_BITS);
        end
      end
      PH_HDR: begin
        if (adv) begin
          if (len_q == '0) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_PAY;
            ld      = 1'b1;
            ld_val  = CNT_W'(len_q);
          end
        end
      end
      default: begin
        if (adv) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hdrq_q <= 1'b0;
      rate_q <= 2'd0;
      len_q  <= '0;
    end else if (cfg_en) begin
      hdrq_q <= hdr_dqpsk_i;
      rate_q <= rate_i;
      len_q  <= len_i;
    end
  end

  assign phase_o    = phase_q;
  assign mod_o      = mod_c;
  assign bit_req_o  = strobe;
  assign sym_bits_o = strobe ? take : 4'd0;
  assign pre_bit_o  = strobe && (phase_q == PH_PRE) && pre_bit_raw;
  assign done_o     = done_q;
endmodule

// File: rtl/dsss_pkt_seq_chk.sv
module dsss_pkt_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase_o,
  input logic [1:0] mod_o,
  input logic       bit_req_o,
  input logic [3:0] sym_bits_o,
  input logic       pre_bit_o,
  input logic       done_o
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase_o == 2'd0 && !bit_req_o));

  assert_pre_dbpsk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1) |-> (mod_o == 2'd0 && (!bit_req_o || sym_bits_o == 4'd1)));

  assert_pre_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_bit_o |-> (bit_req_o && phase_o == 2'd1));

  assert_hdr_no_cck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) |-> (mod_o != 2'd2));

  assert_req_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req_o |-> (phase_o != 2'd0 && sym_bits_o != 4'd0 && sym_bits_o <= 4'd8));

  assert_pre_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'd1 && phase_o != 2'd1) |-> (phase_o == 2'd2));

  assert_hdr_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'd2 && phase_o != 2'd2) |-> (phase_o == 2'd3 || phase_o == 2'd0));

  assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'd0 && phase_o != 2'd0) |-> (phase_o == 2'd1));

  assert_pay_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'd3 && phase_o != 2'd3) |-> (phase_o == 2'd0 && done_o));

  assert_mod_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd0 && $stable(phase_o)) |-> $stable(mod_o));
endmodule

bind dsss_pkt_seq dsss_pkt_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_o    (phase_o),
  .mod_o      (mod_o),
  .bit_req_o  (bit_req_o),
  .sym_bits_o (sym_bits_o),
  .pre_bit_o  (pre_bit_o),
  .done_o     (done_o)
);

// File: tb/dsss_pkt_seq_test.sv
module dsss_pkt_seq_test;
  localparam int          LEN_W = 12;
  localparam int          SYM   = 2;
  localparam logic [15:0] SFD   = 16'hF3A0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             hdr_dqpsk_i = 1'b0;
  logic [1:0]       rate_i = 2'd0;
  logic [LEN_W-1:0] len_i = '0;
  logic [1:0]       phase_o;
  logic [1:0]       mod_o;
  logic             bit_req_o;
  logic [3:0]       sym_bits_o;
  logic             pre_bit_o;
  logic             done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dsss_pkt_seq #(.LEN_W(LEN_W), .SYM_CYC(SYM), .SFD_WORD(SFD)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .hdr_dqpsk_i (hdr_dqpsk_i),
    .rate_i      (rate_i),
    .len_i       (len_i),
    .phase_o     (phase_o),
    .mod_o       (mod_o),
    .bit_req_o   (bit_req_o),
    .sym_bits_o  (sym_bits_o),
    .pre_bit_o   (pre_bit_o),
    .done_o      (done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(phase_o == 2'd0, "R1", "phase in reset", phase_o, 0);
    check(!bit_req_o && !done_o, "R1", "req/done in reset", {bit_req_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(phase_o == 2'd0, "R1", "phase after reset", phase_o, 0);
    check(!bit_req_o && !done_o, "R1", "req/done after reset", {bit_req_o, done_o}, 0);
  endtask

  // Runs one packet and compares each cycle against a model built from the requirements.
  task automatic run_pkt(input bit hq, input logic [1:0] rc, input int len, input bit poke);
    int bps_pay, n_pay, n_sym, done_c, ph, rem, sidx;
    int e_bps, e_mod, e_take, e_pbit;
    string tg;
    bps_pay = (rc == 0) ? 1 : (rc == 1) ? 2 : (rc == 2) ? 4 : 8;
    n_pay   = (len + bps_pay - 1) / bps_pay;
    n_sym   = 144 + (hq ? 24 : 48) + n_pay;
    done_c  = SYM * (n_sym - 1) + 1;
    ph = 1; rem = 144; sidx = 0;
    hdr_dqpsk_i = hq; rate_i = rc; len_i = LEN_W'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c <= done_c + 2; c++) begin
      if (poke && c == 5) begin
        start_i = 1'b1; hdr_dqpsk_i = ~hq; rate_i = ~rc; len_i = LEN_W'(len + 7);
      end
      if (poke && c == 7) start_i = 1'b0;
      begin
        bit exp_req;
        exp_req = (c % SYM == 0) && (c / SYM < n_sym);
        check(bit_req_o == exp_req, poke ? "R10" : "R8", "request timing", bit_req_o, exp_req);
        if (exp_req) begin
          e_bps  = (ph == 1) ? 1 : (ph == 2) ? (hq ? 2 : 1) : bps_pay;
          e_mod  = (ph == 1) ? 0 : (ph == 2) ? int'(hq) : ((rc < 2) ? int'(rc) : 2);
          e_take = (rem < e_bps) ? rem : e_bps;
          e_pbit = (ph == 1) ? ((rem > 16) ? 1 : int'(SFD[rem-1])) : 0;
          if (poke)            tg = "R10";
          else if (sidx == 0)  tg = "R2";
          else if (ph == 1)    tg = "R3";
          else if (ph == 2)    tg = "R4";
          else if (e_take < e_bps) tg = "R6";
          else                 tg = "R5";
          check(int'(phase_o) == ph, tg, "phase", phase_o, ph);
          check(int'(mod_o) == e_mod, poke ? "R10" : "R11", "modulation", mod_o, e_mod);
          check(int'(sym_bits_o) == e_take, tg, "symbol bits", sym_bits_o, e_take);
          check(int'(pre_bit_o) == e_pbit, poke ? "R10" : "R3", "preamble bit", pre_bit_o, e_pbit);
          rem -= e_take;
          sidx++;
          if (rem == 0) begin
            if (ph == 1) begin ph = 2; rem = 48; end
            else if (ph == 2) begin
              if (len == 0) ph = 0;
              else begin ph = 3; rem = len; end
            end else ph = 0;
          end
        end
        check(done_o == (c == done_c), (len == 0) ? "R7" : "R9", "done timing", done_o, (c == done_c));
        if (c == done_c)
          check(phase_o == 2'd0, "R9", "phase at done", phase_o, 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_rates();
    run_pkt(1'b0, 2'd0, 20, 1'b0);
    run_pkt(1'b1, 2'd1, 24, 1'b0);
    run_pkt(1'b0, 2'd2, 32, 1'b0);
    run_pkt(1'b1, 2'd3, 64, 1'b0);
  endtask

  task automatic t_short_tail();
    run_pkt(1'b1, 2'd3, 13, 1'b0);
    run_pkt(1'b0, 2'd2, 7, 1'b0);
    run_pkt(1'b1, 2'd1, 5, 1'b0);
  endtask

  task automatic t_zero_len();
    run_pkt(1'b1, 2'd2, 0, 1'b0);
  endtask

  task automatic t_ignore_midpacket();
    run_pkt(1'b0, 2'd1, 10, 1'b1);
    repeat (3) @(negedge clk);
    check(phase_o == 2'd0 && !bit_req_o, "R10", "idle after ignored start", phase_o, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rates();
    t_short_tail();
    t_zero_len();
    t_ignore_midpacket();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule